// File: doc/BRIEF.md
# Display-File Character Fetch and Pixel Serializer

This block sits beside a CPU bus. It turns instruction fetches made from the upper half of the address space into character fetches for a video picture. An opcode fetch whose top address bit is set goes to memory with that bit cleared. If the returned byte has its video-marker bit (bit 6) set, the CPU is handed a NOP, and the byte is kept as a character code. In the refresh cycle that follows, the block replaces the refresh address with a character-generator address. That address is built from the upper refresh bits (which carry the CPU's I register), the six-bit character code and an external line count.

The pattern byte read in that refresh cycle is inverted when bit 7 of the character code is set. It is then shifted out as eight serial pixels, one per clock. The pixel output is forced to black while the external combined sync is active. The block also raises the CPU's maskable interrupt whenever a refresh address has bit 6 clear. That request is held until the CPU acknowledges it.

All bus controls are active-high. The pixel output uses 1 for black and 0 for white.

Top module: `dfile_pixgen`

## Requirements
- R1: During an opcode fetch (m1, mreq and rd all high), an address with bit 15 set reaches memory with bit 15 cleared. Every other non-refresh cycle passes the CPU address to memory unchanged.
- R2: In an upper-half opcode fetch, a returned byte with bit 6 clear reaches the CPU unchanged.
- R3: In an upper-half opcode fetch, a returned byte with bit 6 set is replaced on the CPU data path by 0x00. A lower-half fetch or a plain memory read is never replaced.
- R4: In the first refresh cycle (rfsh and mreq high) after a replaced fetch, the memory address is {refresh address bits 15..9, code bits 5..0, line count bits 2..0}. A refresh with no pending code passes its address through.
- R5: The byte read in that refresh cycle appears on the pixel output from the next clock, bit 7 first, one bit per clock, for eight clocks.
- R6: When bit 7 of the stored character code is set, all eight pixels are inverted.
- R7: While the sync input is high, the pixel output is 1 (black), whatever the shift register holds.
- R8: Once the eight pixels are out and no new pattern has been loaded, the pixel output is 0 (white).
- R9: A refresh cycle with address bit 6 clear sets the interrupt request at the next clock. One with bit 6 set does not.
- R10: The interrupt request stays set until a clock at which m1 and iorq are both high, and it is clear from the clock after that.
- R11: After reset the interrupt request is low, the pixel output is white and no character code is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock, one bus step per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Address driven by the CPU |
| cpu_m1 | input | 1 | Opcode fetch / acknowledge cycle marker |
| cpu_mreq | input | 1 | Memory request |
| cpu_rd | input | 1 | Read strobe |
| cpu_rfsh | input | 1 | Refresh cycle marker |
| cpu_iorq | input | 1 | I/O request |
| mem_rdata | input | 8 | Byte returned by memory |
| line_cnt | input | 3 | Scan line within the character row |
| sync_active | input | 1 | Combined sync is active |
| mem_addr | output | 16 | Address presented to memory |
| cpu_rdata | output | 8 | Byte presented to the CPU |
| pix_out | output | 1 | Serial pixel, 1 = black |
| int_req | output | 1 | Maskable interrupt request to the CPU |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit data, a 3-bit line count and shifting with the most significant bit first. At these values the exact pattern address can be worked out by hand and compared bit for bit. The full 8-pixel sequence, both plain and inverted, can be traced clock by clock through to the white level that follows it. The interrupt request can be followed through its set, hold and acknowledge phases.

// File: rtl/dfile_pkg.sv
package dfile_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_FETCH = 2'd1,
      CYC_RFSH  = 2'd2,
      CYC_OTHER = 2'd3
   } bus_cycle_e;

   localparam logic [7:0] NOP_OPCODE = 8'h00;
   localparam int         INT_ADDR_BIT = 6;
   localparam logic       PIX_BLACK = 1'b1;
endpackage

// File: rtl/dfile_fetch_mux.sv
module dfile_fetch_mux
   import dfile_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int LINE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_m1,
   input  logic              cpu_mreq,
   input  logic              cpu_rd,
   input  logic              cpu_rfsh,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [LINE_W-1:0] line_cnt,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              load_pat,
   output logic              pat_inv
);
   localparam int CODE_W = DATA_W - 2;
   localparam int I_W    = ADDR_W - CODE_W - LINE_W;
   localparam int VID_BIT = DATA_W - 2;
   localparam int INV_BIT = DATA_W - 1;

   bus_cycle_e        cyc;
   logic              upper;
   logic              vid_hit;
   logic              pend_q;
   logic [DATA_W-1:0] code_q;

   always_comb begin
      if (cpu_rfsh && cpu_mreq)                cyc = CYC_RFSH;
      else if (cpu_m1 && cpu_mreq && cpu_rd)   cyc = CYC_FETCH;
      else if (cpu_mreq)                       cyc = CYC_OTHER;
      else                                     cyc = CYC_IDLE;
   end

   assign upper   = cpu_addr[ADDR_W-1];
   assign vid_hit = (cyc == CYC_FETCH) && upper && mem_rdata[VID_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         code_q <= '0;
      end else if (vid_hit) begin
         pend_q <= 1'b1;
         code_q <= mem_rdata;
      end else if (cyc == CYC_RFSH) begin
         pend_q <= 1'b0;
      end
   end

   always_comb begin
      mem_addr = cpu_addr;
      if (cyc == CYC_FETCH && upper)
         mem_addr[ADDR_W-1] = 1'b0;
      if (cyc == CYC_RFSH && pend_q)
         mem_addr = {cpu_addr[ADDR_W-1 -: I_W], code_q[CODE_W-1:0], line_cnt};
   end

   assign cpu_rdata = vid_hit ? DATA_W'(NOP_OPCODE) : mem_rdata;
   assign load_pat  = (cyc == CYC_RFSH) && pend_q;
   assign pat_inv   = code_q[INV_BIT];
endmodule

// File: rtl/dfile_shifter.sv
module dfile_shifter
   import dfile_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              inv,
   input  logic [DATA_W-1:0] pattern,
   input  logic              sync_active,
   output logic              pix
);
   logic [DATA_W-1:0] sh_q;
   logic              bit_out;

   generate
      if (MSB_FIRST) begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    sh_q <= '0;
            else if (load) sh_q <= inv ? ~pattern : pattern;
            else           sh_q <= sh_q << 1;
         end
         assign bit_out = sh_q[DATA_W-1];
      end else begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    sh_q <= '0;
            else if (load) sh_q <= inv ? ~pattern : pattern;
            else           sh_q <= sh_q >> 1;
         end
         assign bit_out = sh_q[0];
      end
   endgenerate

   assign pix = sync_active ? PIX_BLACK : bit_out;
endmodule

// File: rtl/dfile_intgen.sv
module dfile_intgen
   import dfile_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rfsh,
   input  logic              cpu_mreq,
   input  logic              cpu_m1,
   input  logic              cpu_iorq,
   output logic              int_req
);
   logic set_int;
   logic ack;

   assign set_int = cpu_rfsh && cpu_mreq && !cpu_addr[INT_ADDR_BIT];
   assign ack     = cpu_m1 && cpu_iorq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       int_req <= 1'b0;
      else if (set_int) int_req <= 1'b1;
      else if (ack)     int_req <= 1'b0;
   end
endmodule

// File: rtl/dfile_pixgen.sv
module dfile_pixgen #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int LINE_W    = 3,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_m1,
   input  logic              cpu_mreq,
   input  logic              cpu_rd,
   input  logic              cpu_rfsh,
   input  logic              cpu_iorq,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [LINE_W-1:0] line_cnt,
   input  logic              sync_active,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              pix_out,
   output logic              int_req
);
   localparam int CODE_W = DATA_W - 2;
   localparam int I_W    = ADDR_W - CODE_W - LINE_W;

   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("dfile_pixgen: DATA_W must be at least 8");
      end
      if (I_W < 1) begin : g_bad_addr
         $error("dfile_pixgen: ADDR_W too small for code and line fields");
      end
      if (ADDR_W <= dfile_pkg::INT_ADDR_BIT) begin : g_bad_int
         $error("dfile_pixgen: ADDR_W must cover the interrupt address bit");
      end
   endgenerate

   logic load_pat;
   logic pat_inv;

   dfile_fetch_mux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_m1(cpu_m1),
      .cpu_mreq(cpu_mreq), .cpu_rd(cpu_rd), .cpu_rfsh(cpu_rfsh),
      .mem_rdata(mem_rdata), .line_cnt(line_cnt), .mem_addr(mem_addr),
      .cpu_rdata(cpu_rdata), .load_pat(load_pat), .pat_inv(pat_inv)
   );

   dfile_shifter #(
      .DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)
   ) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load_pat), .inv(pat_inv),
      .pattern(mem_rdata), .sync_active(sync_active), .pix(pix_out)
   );

   dfile_intgen #(
      .ADDR_W(ADDR_W)
   ) u_int (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rfsh(cpu_rfsh),
      .cpu_mreq(cpu_mreq), .cpu_m1(cpu_m1), .cpu_iorq(cpu_iorq),
      .int_req(int_req)
   );
endmodule

// File: rtl/dfile_pixgen_chk.sv
module dfile_pixgen_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_m1,
   input logic              cpu_mreq,
   input logic              cpu_rd,
   input logic              cpu_rfsh,
   input logic              cpu_iorq,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              sync_active,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic              pix_out,
   input logic              int_req
);
   logic fetch_c;
   logic rfsh_c;
   assign fetch_c = cpu_m1 && cpu_mreq && cpu_rd && !cpu_rfsh;
   assign rfsh_c  = cpu_rfsh && cpu_mreq;

   // R1
   upper_fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_c && cpu_addr[ADDR_W-1]) |-> !mem_addr[ADDR_W-1]);

   // R3
   nop_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_c && cpu_addr[ADDR_W-1] && mem_rdata[DATA_W-2]) |-> (cpu_rdata == '0));

   // R2
   exec_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_c && !mem_rdata[DATA_W-2]) |-> (cpu_rdata == mem_rdata));

   // R7
   sync_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_active |-> pix_out);

   // R9
   int_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh_c && !cpu_addr[6]) |=> int_req);

   // R10
   int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_req && !(cpu_m1 && cpu_iorq)) |=> int_req);

   // R10
   int_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_m1 && cpu_iorq && !(rfsh_c && !cpu_addr[6])) |=> !int_req);
endmodule

bind dfile_pixgen dfile_pixgen_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_m1(cpu_m1),
   .cpu_mreq(cpu_mreq), .cpu_rd(cpu_rd), .cpu_rfsh(cpu_rfsh),
   .cpu_iorq(cpu_iorq), .mem_rdata(mem_rdata), .sync_active(sync_active),
   .mem_addr(mem_addr), .cpu_rdata(cpu_rdata), .pix_out(pix_out),
   .int_req(int_req)
);

// File: tb/dfile_pixgen_test.sv
module dfile_pixgen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_m1 = 0, cpu_mreq = 0, cpu_rd = 0, cpu_rfsh = 0, cpu_iorq = 0;
   logic [7:0]  mem_rdata = '0;
   logic [2:0]  line_cnt = 3'd5;
   logic        sync_active = 1'b0;
   logic [15:0] mem_addr;
   logic [7:0]  cpu_rdata;
   logic        pix_out;
   logic        int_req;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   dfile_pixgen uut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_m1(cpu_m1),
      .cpu_mreq(cpu_mreq), .cpu_rd(cpu_rd), .cpu_rfsh(cpu_rfsh),
      .cpu_iorq(cpu_iorq), .mem_rdata(mem_rdata), .line_cnt(line_cnt),
      .sync_active(sync_active), .mem_addr(mem_addr), .cpu_rdata(cpu_rdata),
      .pix_out(pix_out), .int_req(int_req)
   );

   // {addr, data, m1 mreq rd rfsh iorq, expected cpu byte, expected mem addr}
   localparam logic [52:0] VEC [6] = '{
      {16'h1234, 8'h45, 5'b11100, 8'h45, 16'h1234},
      {16'hC123, 8'h05, 5'b11100, 8'h05, 16'h4123},
      {16'h3A40, 8'h00, 5'b01010, 8'h00, 16'h3A40},
      {16'h8010, 8'h6A, 5'b11100, 8'h00, 16'h0010},
      {16'h1E45, 8'h00, 5'b01010, 8'h00, 16'h1F55},
      {16'h9000, 8'h77, 5'b01100, 8'h77, 16'h9000}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic [15:0] a, input logic [7:0] d, input logic [4:0] ctl);
      @(negedge clk);
      cpu_addr  = a;
      mem_rdata = d;
      {cpu_m1, cpu_mreq, cpu_rd, cpu_rfsh, cpu_iorq} = ctl;
      #5;
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] pat;
      // R11 reset state
      #15;
      check("R11 pix reset", 16'(pix_out), 16'h0);
      check("R11 int reset", 16'(int_req), 16'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // vector walk: R1 R2 R3 R4
      for (int i = 0; i < 6; i++) begin
         step(VEC[i][52:37], VEC[i][36:29], VEC[i][28:24]);
         check($sformatf("R1 R2 R3 R4 vector %0d cpu data", i), 16'(cpu_rdata), 16'(VEC[i][23:16]));
         check($sformatf("R1 R4 vector %0d mem addr", i), mem_addr, VEC[i][15:0]);
      end
      step(16'h0000, 8'h00, 5'b00000);
      // R9: refreshes in the walk all had bit 6 set
      check("R9 no int on A6 set", 16'(int_req), 16'h0);
      for (int i = 0; i < 10; i++) step(16'h0000, 8'h00, 5'b00000);

      // R5 R8 plain pattern
      pat = 8'hB4;
      step(16'h8041, 8'h41, 5'b11100);
      step(16'h2040, pat, 5'b01010);
      for (int i = 0; i < 9; i++) begin
         step(16'h0000, 8'h00, 5'b00000);
         check(i < 8 ? "R5 pixel" : "R8 white after pattern", 16'(pix_out),
               16'(i < 8 ? pat[7-i] : 1'b0));
      end

      // R6 inverted pattern
      step(16'h8041, 8'hC1, 5'b11100);
      step(16'h2040, 8'hB4, 5'b01010);
      pat = ~8'hB4;
      for (int i = 0; i < 9; i++) begin
         step(16'h0000, 8'h00, 5'b00000);
         check(i < 8 ? "R6 inverted pixel" : "R8 white after inverted", 16'(pix_out),
               16'(i < 8 ? pat[7-i] : 1'b0));
      end

      // R7 sync forces black over a white pattern
      step(16'h8040, 8'h40, 5'b11100);
      step(16'h2040, 8'h00, 5'b01010);
      sync_active = 1'b1;
      step(16'h0000, 8'h00, 5'b00000);
      check("R7 sync black", 16'(pix_out), 16'h1);
      sync_active = 1'b0;
      step(16'h0000, 8'h00, 5'b00000);
      check("R7 released white", 16'(pix_out), 16'h0);

      // R9 R10 interrupt
      step(16'h2000, 8'h00, 5'b01010);
      step(16'h0000, 8'h00, 5'b00000);
      check("R9 int set", 16'(int_req), 16'h1);
      step(16'h0000, 8'h00, 5'b00000);
      check("R10 int held", 16'(int_req), 16'h1);
      step(16'h0038, 8'hFF, 5'b10001);
      check("R10 int held in ack cycle", 16'(int_req), 16'h1);
      step(16'h0000, 8'h00, 5'b00000);
      check("R10 int cleared", 16'(int_req), 16'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule